// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control for a small processor core. Peripherals raise request lines at any time, and each request is held in a per-line latch until it is served. The core reports the end of every instruction with a strobe. Only at that point does the sequencer look at the pending requests. If a request is pending and interrupts are not masked, it accepts the lowest-numbered line.

On acceptance it runs a fixed hardware interrupt cycle. First it raises an acknowledge pulse and masks further interrupts. It then reads an 8-bit vector number, pushes the interrupted program counter and the status word to the stack, and redirects the core to the handler entry address, which is `VEC_BASE + 4 * vector`.

A return strobe from the core reverses the sequence. The sequencer pops the status word and then the program counter, and redirects the core to the popped address. An enable strobe clears the mask flag. When that strobe comes from inside a handler, new requests are still held off until the following return sequence has completed.

Top module: `intr_seq`

## Requirements
- R1: After reset `mask_o` is 1, all request latches are empty, and `inta_o`, `redirect_o`, `push_valid_o` and `pop_req_o` are 0. After an enable strobe, an instruction boundary with no request ever raised causes no acknowledge.
- R2: A request line held high for a single cycle between boundaries stays latched and is accepted at the next instruction boundary.
- R3: A pending request is never accepted while `instr_done_i` is low. `inta_o` only rises in the cycle after a cycle with `instr_done_i` high.
- R4: While `mask_o` is 1, pending requests are not accepted and are not lost. They are accepted at a later boundary once the mask is clear.
- R5: Acceptance at the boundary in cycle N makes `inta_o` high for exactly cycle N+1, with `mask_o` already 1 in that cycle.
- R6: When several lines are pending, the lowest-numbered line wins. `inta_id_o` carries its number (binary), only that line's latch is cleared, and the other lines remain pending.
- R7: `vec_i` is sampled in the cycle after the `inta_o` cycle. `redirect_o` is then high for one cycle with `redirect_pc_o = VEC_BASE + 4*vec_i` (modulo 2^PC_W).
- R8: Before that redirect the block pushes the program counter and then the status word (zero-extended to PC_W). Each push holds `push_valid_o` and `push_data_o` steady until `push_ready_i` is high.
- R9: An enable strobe outside a handler clears `mask_o` in the next cycle, and the next boundary can accept a request.
- R10: An enable strobe inside a handler clears `mask_o`, but no request is accepted until the return sequence that follows has finished.
- R11: A return strobe pops the status word first and the program counter second, each popped when `pop_valid_i` is high. `redirect_o` and `status_load_o` are then high for one cycle, carrying the popped PC and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_REQ | Peripheral request lines, latched while high |
| instr_done_i | input | 1 | End-of-instruction strobe from the core |
| ei_i | input | 1 | Enable-interrupt strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | PC_W | Resume address of the interrupted program at the boundary |
| status_i | input | STAT_W | Core status word at the boundary |
| vec_i | input | VEC_W | Vector number supplied after acknowledge |
| inta_o | output | 1 | Interrupt acknowledge pulse |
| inta_id_o | output | ID_W | Number of the acknowledged line |
| mask_o | output | 1 | Interrupt mask flag |
| push_valid_o | output | 1 | Stack push request |
| push_data_o | output | PC_W | Word to push |
| push_ready_i | input | 1 | Stack accepts the push |
| pop_req_o | output | 1 | Stack pop request |
| pop_valid_i | input | 1 | Popped word is valid |
| pop_data_i | input | PC_W | Popped word |
| redirect_o | output | 1 | Redirect the core's PC |
| redirect_pc_o | output | PC_W | Redirect target |
| status_load_o | output | 1 | Restore the status word |
| restore_status_o | output | STAT_W | Status word to restore |

## Verification
The acceptance path is exercised with single-line requests, requests on several lines at once, and empty cycles that drain lines left pending by earlier requests. Together these separate priority selection and per-line clearing from plain latching. Vector values 0x00, 0x7F, 0x80 and 0xFF check the scaling and addition of the entry address at both ends of the vector range. The tests also cover a request raised between boundaries, a boundary reached while masked, an enable strobe followed by a boundary inside a handler, and a stalled stack push. These show whether the block samples only at boundaries, holds off acceptance until the return has completed, and keeps each push stable while the stack is not ready.

// File: rtl/isq_pkg.sv
package isq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACK,
      ST_VEC,
      ST_PUSH_PC,
      ST_PUSH_ST,
      ST_JUMP,
      ST_POP_ST,
      ST_POP_PC,
      ST_RET
   } isq_state_e;
endpackage

// File: rtl/isq_pending.sv
// Per-line request latches with lowest-number-first selection.
module isq_pending #(
   parameter int NUM_REQ = 8,
   parameter int ID_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_i,
   input  logic               take_i,
   input  logic [ID_W-1:0]    take_id_i,
   output logic               any_o,
   output logic [ID_W-1:0]    top_id_o
);
   logic [NUM_REQ-1:0] pend_q;

   for (genvar k = 0; k < NUM_REQ; k++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend_q[k] <= 1'b0;
         else
            pend_q[k] <= (pend_q[k] & ~(take_i && (take_id_i == ID_W'(k)))) | req_i[k];
      end
   end

   always_comb begin
      top_id_o = '0;
      for (int k = NUM_REQ - 1; k >= 0; k--) begin
         if (pend_q[k]) top_id_o = ID_W'(k);
      end
   end

   assign any_o = |pend_q;
endmodule

// File: rtl/isq_mask.sv
// Mask flag plus the hold that defers re-enable until the return finishes.
module isq_mask (
   input  logic clk,
   input  logic rst_n,
   input  logic accept_i,
   input  logic ei_i,
   input  logic ret_done_i,
   output logic mask_o,
   output logic hold_o
);
   logic in_isr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o   <= 1'b1;
         in_isr_q <= 1'b0;
         hold_o   <= 1'b0;
      end else begin
         if (accept_i)  mask_o <= 1'b1;
         else if (ei_i) mask_o <= 1'b0;

         if (accept_i)        in_isr_q <= 1'b1;
         else if (ret_done_i) in_isr_q <= 1'b0;

         if (ret_done_i)            hold_o <= 1'b0;
         else if (ei_i && in_isr_q) hold_o <= 1'b1;
      end
   end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
   import isq_pkg::*;
#(
   parameter int          NUM_REQ  = 8,
   parameter int          ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   parameter int          PC_W     = 16,
   parameter int          STAT_W   = 8,
   parameter int          VEC_W    = 8,
   parameter logic [15:0] VEC_BASE = 16'h0400
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_i,
   input  logic               instr_done_i,
   input  logic               ei_i,
   input  logic               reti_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [STAT_W-1:0]  status_i,
   input  logic [VEC_W-1:0]   vec_i,
   output logic               inta_o,
   output logic [ID_W-1:0]    inta_id_o,
   output logic               mask_o,
   output logic               push_valid_o,
   output logic [PC_W-1:0]    push_data_o,
   input  logic               push_ready_i,
   output logic               pop_req_o,
   input  logic               pop_valid_i,
   input  logic [PC_W-1:0]    pop_data_i,
   output logic               redirect_o,
   output logic [PC_W-1:0]    redirect_pc_o,
   output logic               status_load_o,
   output logic [STAT_W-1:0]  restore_status_o
);
   localparam int MIN_ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

   if (NUM_REQ < 1 || NUM_REQ > 64) begin : g_bad_req
      $error("intr_seq: NUM_REQ out of range");
   end
   if (ID_W < MIN_ID_W) begin : g_bad_id
      $error("intr_seq: ID_W too narrow for NUM_REQ");
   end
   if (STAT_W > PC_W) begin : g_bad_stat
      $error("intr_seq: status must fit in one stack word");
   end
   if (PC_W < VEC_W + 2) begin : g_bad_vec
      $error("intr_seq: PC_W cannot hold a scaled vector");
   end

   isq_state_e          state_q;
   logic                any_pend, hold, accept, ret_done;
   logic [ID_W-1:0]     top_id;
   logic [PC_W-1:0]     pc_q, entry_q, pc_pop_q;
   logic [STAT_W-1:0]   st_q;

   assign ret_done = (state_q == ST_RET);
   assign accept   = (state_q == ST_IDLE) && instr_done_i && !reti_i &&
                     any_pend && !mask_o && !hold;

   isq_pending #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .take_i    (accept),
      .take_id_i (top_id),
      .any_o     (any_pend),
      .top_id_o  (top_id)
   );

   isq_mask u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .ei_i       (ei_i),
      .ret_done_i (ret_done),
      .mask_o     (mask_o),
      .hold_o     (hold)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q          <= ST_IDLE;
         inta_id_o        <= '0;
         pc_q             <= '0;
         st_q             <= '0;
         entry_q          <= '0;
         pc_pop_q         <= '0;
         restore_status_o <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (reti_i) begin
                  state_q <= ST_POP_ST;
               end else if (accept) begin
                  state_q   <= ST_ACK;
                  inta_id_o <= top_id;
                  pc_q      <= pc_i;
                  st_q      <= status_i;
               end
            end
            ST_ACK: state_q <= ST_VEC;
            ST_VEC: begin
               entry_q <= PC_W'(VEC_BASE) + (PC_W'(vec_i) << 2);
               state_q <= ST_PUSH_PC;
            end
            ST_PUSH_PC: if (push_ready_i) state_q <= ST_PUSH_ST;
            ST_PUSH_ST: if (push_ready_i) state_q <= ST_JUMP;
            ST_JUMP:    state_q <= ST_IDLE;
            ST_POP_ST: begin
               if (pop_valid_i) begin
                  restore_status_o <= pop_data_i[STAT_W-1:0];
                  state_q          <= ST_POP_PC;
               end
            end
            ST_POP_PC: begin
               if (pop_valid_i) begin
                  pc_pop_q <= pop_data_i;
                  state_q  <= ST_RET;
               end
            end
            ST_RET:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign inta_o        = (state_q == ST_ACK);
   assign push_valid_o  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_ST);
   assign push_data_o   = (state_q == ST_PUSH_PC) ? pc_q : PC_W'(st_q);
   assign pop_req_o     = (state_q == ST_POP_ST) || (state_q == ST_POP_PC);
   assign redirect_o    = (state_q == ST_JUMP) || ret_done;
   assign redirect_pc_o = ret_done ? pc_pop_q : entry_q;
   assign status_load_o = ret_done;
endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_done_i,
   input logic            inta_o,
   input logic            mask_o,
   input logic            push_valid_o,
   input logic [PC_W-1:0] push_data_o,
   input logic            push_ready_i,
   input logic            pop_req_o,
   input logic            redirect_o,
   input logic            status_load_o
);
   assert_inta_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inta_o |=> !inta_o);

   assert_inta_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inta_o |-> mask_o);

   assert_inta_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inta_o) |-> $past(instr_done_i));

   assert_push_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_data_o)));

   assert_redirect_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !redirect_o);

   assert_stack_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_valid_o && pop_req_o));

   assert_restore_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
      status_load_o |-> redirect_o);
endmodule

bind intr_seq isq_checker #(.PC_W(PC_W)) u_isq_checker (.*);

// File: tb/tb_intr_seq.sv
module tb_intr_seq;
   localparam int          NREQ = 8;
   localparam logic [15:0] BASE = 16'h0400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req_i = '0;
   logic        instr_done_i = 1'b0, ei_i = 1'b0, reti_i = 1'b0;
   logic [15:0] pc_i = '0;
   logic [7:0]  status_i = '0;
   logic [7:0]  vec_i = '0;
   logic        inta_o, mask_o, push_valid_o, pop_req_o, redirect_o, status_load_o;
   logic [2:0]  inta_id_o;
   logic [15:0] push_data_o, pop_data_i, redirect_pc_o;
   logic        push_ready_i = 1'b1;
   logic        pop_valid_i;
   logic [7:0]  restore_status_o;

   int tests = 0, fails = 0;
   logic [15:0] stk [0:7];
   int sp = 0;

   always #2 clk = ~clk;

   intr_seq #(.NUM_REQ(NREQ), .VEC_BASE(BASE)) dut (.*);

   // stack model
   assign pop_valid_i = pop_req_o;
   assign pop_data_i  = (sp > 0) ? stk[sp-1] : 16'hDEAD;
   always @(posedge clk) begin
      if (push_valid_o && push_ready_i) begin
         stk[sp] <= push_data_o;
         sp <= sp + 1;
      end else if (pop_req_o && pop_valid_i && sp > 0) begin
         sp <= sp - 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic take_irq(input logic [2:0] id, input logic [7:0] vec, input logic [15:0] pc,
                           input logic [7:0] st, input int stall);
      logic [15:0] exp_addr;
      bit seen;
      exp_addr = BASE + {6'd0, vec, 2'b00};
      pc_i = pc; status_i = st; instr_done_i = 1'b1;
      @(negedge clk);
      instr_done_i = 1'b0;
      chk(inta_o == 1'b1, "R5 inta after boundary", inta_o, 1);
      chk(inta_id_o == id, "R6 acknowledged line", inta_id_o, id);
      chk(mask_o == 1'b1, "R5 mask set with inta", mask_o, 1);
      vec_i = vec;
      push_ready_i = (stall == 0);
      @(negedge clk);
      chk(inta_o == 1'b0, "R5 inta one cycle", inta_o, 0);
      if (stall > 0) begin
         repeat (stall) @(negedge clk);
         chk(push_valid_o && !redirect_o && push_data_o == pc, "R8 push held while stalled",
             push_data_o, pc);
         push_ready_i = 1'b1;
      end
      seen = 0;
      for (int i = 0; i < 10 && !seen; i++) begin
         @(negedge clk);
         if (redirect_o) seen = 1;
      end
      chk(seen && redirect_pc_o == exp_addr, "R7 entry address", redirect_pc_o, exp_addr);
      chk(sp == 2 && stk[0] == pc && stk[1] == {8'h00, st}, "R8 push order pc then status",
          stk[1], {8'h00, st});
      @(negedge clk);
      chk(redirect_o == 1'b0, "R7 redirect one cycle", redirect_o, 0);
   endtask

   task automatic do_return(input logic [15:0] pc, input logic [7:0] st);
      bit seen;
      ei_i = 1'b1;
      @(negedge clk);
      ei_i = 1'b0;
      chk(mask_o == 1'b0, "R10 enable clears mask", mask_o, 0);
      instr_done_i = 1'b1;
      @(negedge clk);
      instr_done_i = 1'b0;
      chk(inta_o == 1'b0, "R10 no accept before return", inta_o, 0);
      reti_i = 1'b1;
      @(negedge clk);
      reti_i = 1'b0;
      seen = 0;
      for (int i = 0; i < 10 && !seen; i++) begin
         if (redirect_o) seen = 1;
         else @(negedge clk);
      end
      chk(seen && redirect_pc_o == pc, "R11 return address", redirect_pc_o, pc);
      chk(status_load_o && restore_status_o == st, "R11 restored status", restore_status_o, st);
      @(negedge clk);
      chk(sp == 0 && mask_o == 1'b0, "R11 stack drained, mask clear", sp, 0);
   endtask

   // req pattern, vector, expected line
   localparam logic [18:0] TBL [6] = '{
      {8'b0000_0100, 8'h10, 3'd2},
      {8'b1010_0000, 8'h20, 3'd5},
      {8'b0000_0000, 8'hFF, 3'd7},
      {8'b0000_0001, 8'h00, 3'd0},
      {8'b1000_0001, 8'h7F, 3'd0},
      {8'b0000_0000, 8'h80, 3'd7}
   };

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mask_o == 1'b1, "R1 mask after reset", mask_o, 1);
      chk(!inta_o && !redirect_o && !push_valid_o && !pop_req_o, "R1 idle outputs", inta_o, 0);
      // R9 enable outside handler
      ei_i = 1'b1; @(negedge clk); ei_i = 1'b0;
      chk(mask_o == 1'b0, "R9 mask cleared by enable", mask_o, 0);
      instr_done_i = 1'b1; @(negedge clk); instr_done_i = 1'b0;
      chk(inta_o == 1'b0, "R1 latches empty after reset", inta_o, 0);
      // R3: one-cycle request, no boundary yet
      req_i = 8'b0001_0000; @(negedge clk); req_i = '0;
      repeat (3) begin
         @(negedge clk);
         chk(inta_o == 1'b0, "R3 no accept without boundary", inta_o, 0);
      end
      // R2: latched pulse accepted at the boundary
      take_irq(3'd4, 8'h01, 16'h2000, 8'h11, 0);
      // R4: masked, request stays pending
      req_i = 8'b0000_0010; @(negedge clk); req_i = '0;
      instr_done_i = 1'b1; @(negedge clk); instr_done_i = 1'b0;
      chk(inta_o == 1'b0, "R4 no accept while masked", inta_o, 0);
      do_return(16'h2000, 8'h11);
      // R4 pending survives, taken now; R8 stalled push
      take_irq(3'd1, 8'h03, 16'h2100, 8'h22, 3);
      do_return(16'h2100, 8'h22);
      // table walk: priority, draining leftovers, vector range
      for (int i = 0; i < 6; i++) begin
         req_i = TBL[i][18:11]; @(negedge clk); req_i = '0;
         take_irq(TBL[i][2:0], TBL[i][10:3], 16'h1000 + 16'(i * 16), 8'hA0 + 8'(i), 0);
         do_return(16'h1000 + 16'(i * 16), 8'hA0 + 8'(i));
      end
      // R6: all lines drained
      instr_done_i = 1'b1; @(negedge clk); instr_done_i = 1'b0;
      chk(inta_o == 1'b0, "R6 no lines left pending", inta_o, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule